// File: doc/BRIEF.md
# Stereo Automatic Level Control Engine

This block steers a single 7-bit input gain code, in 0.5 dB units, from a stream of signed left and right audio samples. Code 0 is the lowest gain (-8 dB). When a sample strobe carries a loud sample on either channel, the block lowers the code by a programmable number of steps. It stops at code 0. After enough consecutive quiet strobes, it raises the code by one or two steps. The code never goes above a reference ceiling given on an input port.

The shared code is the target. Each channel holds its own committed copy of that target. In gated mode, a channel takes up a new target only when its own signal changes sign, or when a timeout of sample strobes runs out. In bypass mode, both channels follow the target in the same clock edge that changes it. All configuration arrives on plain input ports. Loudness is measured as the absolute value of the sample against fixed fractions of full scale.

Top module: `stereo_alc`

## Requirements
- R1: While reset is high, the target and both committed gains load the value on `cfg_ceiling`, and they keep that value after reset is released.
- R2: The trigger level is compared with the absolute value of each sample. With a 16-bit sample, `cfg_hi_thr`=0 triggers the limiter on a magnitude above 16423 (-6 dBFS), and `cfg_hi_thr`=1 triggers it on a magnitude above 20675 (-4 dBFS). A loud sample on either channel triggers it.
- R3: On a limiter strobe, the target drops by `cfg_atten_sel`+1 steps: codes 0, 1, 2 and 3 remove 1, 2, 3 and 4 steps. The target changes only on a clock edge that has `smp_valid` high.
- R4: Attenuation saturates at code 0 and never wraps.
- R5: A strobe with no limiter trigger and no sample in the hold band is a quiet strobe. The hold band is magnitude above 13045 and up to 16423 for `cfg_hi_thr`=0, and above 16423 and up to 20675 for `cfg_hi_thr`=1. Recovery happens on the `cfg_wait`-th consecutive quiet strobe. A hold-band sample or a limiter event restarts the count.
- R6: Recovery adds 1 step when `cfg_rec_big`=0 and 2 steps when it is 1. The result is clipped to `cfg_ceiling`.
- R7: With `cfg_zc_bypass`=0, a channel whose committed gain differs from the target commits the target on a strobe where that channel's sign bit (bit SMP_W-1) differs from the sign bit of its previous sample.
- R8: With `cfg_zc_bypass`=0, a channel that stays pending for `cfg_wait` strobes without a sign change commits the target on the last of those strobes. Each channel does this on its own.
- R9: With `cfg_zc_bypass`=1, both committed gains change in the same clock edge as the target and equal it.
- R10: With `cfg_zc_bypass`=0, the committed gains change only on clock edges where `smp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe for both channels |
| smp_left | input | SMP_W | Left sample, two's complement |
| smp_right | input | SMP_W | Right sample, two's complement |
| cfg_hi_thr | input | 1 | Selects the trigger level and hold band |
| cfg_atten_sel | input | 2 | Limiter step count minus one |
| cfg_rec_big | input | 1 | Recovery step: 0 gives 1, 1 gives 2 |
| cfg_zc_bypass | input | 1 | 1 applies gain at once, 0 waits for a zero crossing or timeout |
| cfg_ceiling | input | 7 | Reference ceiling and reset gain |
| cfg_wait | input | WAIT_W | Strobes for the recovery wait and the commit timeout |
| gain_target | output | 7 | Shared pending gain code |
| gain_left | output | 7 | Left committed gain code |
| gain_right | output | 7 | Right committed gain code |

## Verification
The hardest state to reach is a channel committing on timeout while the other channel has already committed at its own zero crossing, with the target not moving in between. Quiet strobes would start recovery in the same window. The stimulus therefore makes one limiter event, then sends hold-band samples. These keep the recovery count cleared: the left channel flips sign once and the right channel stays positive. The bench then watches the right gain stay put until the `cfg_wait`-th pending strobe.

// File: rtl/stereo_alc_pkg.sv
package stereo_alc_pkg;

    localparam int GAIN_W = 7;
    localparam int NCH    = 2;

    typedef logic [GAIN_W-1:0] gain_t;

    // Level fractions of full scale, in Q15
    localparam longint unsigned LVL_M4DB = 64'd20675;
    localparam longint unsigned LVL_M6DB = 64'd16423;
    localparam longint unsigned LVL_M8DB = 64'd13045;

    typedef struct packed {
        logic over;
        logic band;
    } lvl_t;

    typedef struct packed {
        logic       hi_thr;
        logic [1:0] atten;
        logic       rec_big;
        logic       zc_bypass;
        gain_t      ceiling;
    } cfg_t;

    function automatic longint unsigned scale_q15(longint unsigned q, int w);
        if (w >= 16) return q << (w - 16);
        return q >> (16 - w);
    endfunction

    function automatic gain_t sat_sub(gain_t g, logic [2:0] s);
        if (g > gain_t'(s)) return g - gain_t'(s);
        return '0;
    endfunction

    function automatic gain_t capped_add(gain_t g, logic [1:0] s, gain_t c);
        logic [GAIN_W:0] sum;
        sum = {1'b0, g} + (GAIN_W+1)'(s);
        if (g >= c) return g;
        if (sum > {1'b0, c}) return c;
        return sum[GAIN_W-1:0];
    endfunction

endpackage

// File: rtl/stereo_alc_level.sv
module stereo_alc_level
    import stereo_alc_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic signed [SMP_W-1:0] smp,
    input  logic                    hi_thr,
    output lvl_t                    lvl
);
    localparam logic [SMP_W-1:0] LV4 = SMP_W'(scale_q15(LVL_M4DB, SMP_W));
    localparam logic [SMP_W-1:0] LV6 = SMP_W'(scale_q15(LVL_M6DB, SMP_W));
    localparam logic [SMP_W-1:0] LV8 = SMP_W'(scale_q15(LVL_M8DB, SMP_W));

    logic [SMP_W-1:0] mag;
    logic [SMP_W-1:0] lim_lvl;
    logic [SMP_W-1:0] band_lo;

    // Two's complement magnitude; the most negative code maps to 2^(SMP_W-1)
    assign mag     = smp[SMP_W-1] ? $unsigned(-smp) : $unsigned(smp);
    assign lim_lvl = hi_thr ? LV4 : LV6;
    assign band_lo = hi_thr ? LV6 : LV8;

    always_comb begin
        lvl.over = (mag > lim_lvl);
        lvl.band = !lvl.over && (mag > band_lo);
    end
endmodule

// File: rtl/stereo_alc_gain.sv
module stereo_alc_gain
    import stereo_alc_pkg::*;
#(
    parameter int WAIT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic              over_any,
    input  logic              band_any,
    input  cfg_t              cfg,
    input  logic [WAIT_W-1:0] wait_lim,
    output gain_t             target,
    output gain_t             target_nxt,
    output logic [WAIT_W-1:0] wait_cnt
);
    logic [2:0]        att_steps;
    logic [1:0]        rec_steps;
    logic [WAIT_W:0]   cnt_inc;
    logic [WAIT_W-1:0] cnt_nxt;

    assign att_steps = {1'b0, cfg.atten} + 3'd1;
    assign rec_steps = cfg.rec_big ? 2'd2 : 2'd1;
    assign cnt_inc   = {1'b0, wait_cnt} + 1'b1;

    always_comb begin
        target_nxt = target;
        cnt_nxt    = wait_cnt;
        if (smp_valid) begin
            if (over_any) begin
                target_nxt = sat_sub(target, att_steps);
                cnt_nxt    = '0;
            end else if (band_any) begin
                cnt_nxt    = '0;
            end else if (cnt_inc >= {1'b0, wait_lim}) begin
                target_nxt = capped_add(target, rec_steps, cfg.ceiling);
                cnt_nxt    = '0;
            end else begin
                cnt_nxt    = cnt_inc[WAIT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target   <= cfg.ceiling;
            wait_cnt <= '0;
        end else begin
            target   <= target_nxt;
            wait_cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/stereo_alc_commit.sv
module stereo_alc_commit
    import stereo_alc_pkg::*;
#(
    parameter int WAIT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic              smp_sign,
    input  logic              bypass,
    input  logic [WAIT_W-1:0] wait_lim,
    input  gain_t             ceiling,
    input  gain_t             target,
    input  gain_t             target_nxt,
    output gain_t             gain
);
    logic              prev_sign;
    logic [WAIT_W-1:0] to_cnt;
    logic [WAIT_W:0]   to_nxt;
    logic              crossed;
    logic              timed_out;

    assign to_nxt    = {1'b0, to_cnt} + 1'b1;
    assign crossed   = (smp_sign != prev_sign);
    assign timed_out = (to_nxt >= {1'b0, wait_lim});

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sign <= 1'b0;
            to_cnt    <= '0;
            gain      <= ceiling;
        end else begin
            if (smp_valid) prev_sign <= smp_sign;
            if (bypass) begin
                gain   <= target_nxt;
                to_cnt <= '0;
            end else if (gain != target) begin
                if (smp_valid) begin
                    if (crossed || timed_out) begin
                        gain   <= target;
                        to_cnt <= '0;
                    end else begin
                        to_cnt <= to_nxt[WAIT_W-1:0];
                    end
                end
            end else begin
                to_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/stereo_alc.sv
module stereo_alc
    import stereo_alc_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int WAIT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_left,
    input  logic signed [SMP_W-1:0] smp_right,
    input  logic                    cfg_hi_thr,
    input  logic [1:0]              cfg_atten_sel,
    input  logic                    cfg_rec_big,
    input  logic                    cfg_zc_bypass,
    input  logic [6:0]              cfg_ceiling,
    input  logic [WAIT_W-1:0]       cfg_wait,
    output logic [6:0]              gain_target,
    output logic [6:0]              gain_left,
    output logic [6:0]              gain_right
);
    cfg_t                    cfg;
    logic signed [SMP_W-1:0] smp_a  [NCH];
    lvl_t                    lvl_a  [NCH];
    gain_t                   gain_a [NCH];
    logic                    over_any;
    logic                    band_any;
    gain_t                   target;
    gain_t                   target_nxt;
    logic [WAIT_W-1:0]       wait_cnt;

    always_comb begin
        cfg.hi_thr    = cfg_hi_thr;
        cfg.atten     = cfg_atten_sel;
        cfg.rec_big   = cfg_rec_big;
        cfg.zc_bypass = cfg_zc_bypass;
        cfg.ceiling   = cfg_ceiling;
    end

    assign smp_a[0] = smp_left;
    assign smp_a[1] = smp_right;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        stereo_alc_level #(.SMP_W(SMP_W)) level_i (
            .smp    (smp_a[ch]),
            .hi_thr (cfg.hi_thr),
            .lvl    (lvl_a[ch])
        );

        stereo_alc_commit #(.WAIT_W(WAIT_W)) commit_i (
            .clk        (clk),
            .rst        (rst),
            .smp_valid  (smp_valid),
            .smp_sign   (smp_a[ch][SMP_W-1]),
            .bypass     (cfg.zc_bypass),
            .wait_lim   (cfg_wait),
            .ceiling    (cfg.ceiling),
            .target     (target),
            .target_nxt (target_nxt),
            .gain       (gain_a[ch])
        );
    end

    assign over_any = lvl_a[0].over | lvl_a[1].over;
    assign band_any = lvl_a[0].band | lvl_a[1].band;

    stereo_alc_gain #(.WAIT_W(WAIT_W)) gain_i (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .over_any   (over_any),
        .band_any   (band_any),
        .cfg        (cfg),
        .wait_lim   (cfg_wait),
        .target     (target),
        .target_nxt (target_nxt),
        .wait_cnt   (wait_cnt)
    );

    assign gain_target = target;
    assign gain_left   = gain_a[0];
    assign gain_right  = gain_a[1];
endmodule

// File: rtl/stereo_alc_chk.sv
module stereo_alc_chk #(
    parameter int WAIT_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic              cfg_zc_bypass,
    input logic [1:0]        cfg_atten_sel,
    input logic [6:0]        cfg_ceiling,
    input logic              over_any,
    input logic              band_any,
    input logic [WAIT_W-1:0] wait_cnt,
    input logic [6:0]        gain_target,
    input logic [6:0]        gain_left,
    input logic [6:0]        gain_right
);
    logic [6:0] att_n;
    assign att_n = 7'({1'b0, cfg_atten_sel}) + 7'd1;

    // R3 R4
    limiter_step_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && over_any) |=> gain_target ==
            (($past(gain_target) > $past(att_n)) ? $past(gain_target) - $past(att_n) : 7'd0));

    // R3
    target_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(gain_target));

    // R5
    wait_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (over_any || band_any)) |=> wait_cnt == '0);

    // R6
    ceiling_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_target > $past(gain_target)) |-> gain_target <= cfg_ceiling);

    // R9
    bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_zc_bypass |=> (gain_left == gain_target && gain_right == gain_target));

    // R10
    gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !cfg_zc_bypass) |=> ($stable(gain_left) && $stable(gain_right)));
endmodule

bind stereo_alc stereo_alc_chk #(.WAIT_W(WAIT_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .smp_valid     (smp_valid),
    .cfg_zc_bypass (cfg_zc_bypass),
    .cfg_atten_sel (cfg_atten_sel),
    .cfg_ceiling   (cfg_ceiling),
    .over_any      (over_any),
    .band_any      (band_any),
    .wait_cnt      (wait_cnt),
    .gain_target   (gain_target),
    .gain_left     (gain_left),
    .gain_right    (gain_right)
);

// File: tb/stereo_alc_tb_top.sv
module stereo_alc_tb_top;
    localparam int SMP_W  = 16;
    localparam int WAIT_W = 12;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    smp_valid = 1'b0;
    logic signed [SMP_W-1:0] smp_left = '0;
    logic signed [SMP_W-1:0] smp_right = '0;
    logic                    cfg_hi_thr = 1'b0;
    logic [1:0]              cfg_atten_sel = 2'd0;
    logic                    cfg_rec_big = 1'b0;
    logic                    cfg_zc_bypass = 1'b1;
    logic [6:0]              cfg_ceiling = 7'h40;
    logic [WAIT_W-1:0]       cfg_wait = 12'd4;
    logic [6:0]              gain_target;
    logic [6:0]              gain_left;
    logic [6:0]              gain_right;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    stereo_alc #(.SMP_W(SMP_W), .WAIT_W(WAIT_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .smp_valid     (smp_valid),
        .smp_left      (smp_left),
        .smp_right     (smp_right),
        .cfg_hi_thr    (cfg_hi_thr),
        .cfg_atten_sel (cfg_atten_sel),
        .cfg_rec_big   (cfg_rec_big),
        .cfg_zc_bypass (cfg_zc_bypass),
        .cfg_ceiling   (cfg_ceiling),
        .cfg_wait      (cfg_wait),
        .gain_target   (gain_target),
        .gain_left     (gain_left),
        .gain_right    (gain_right)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [6:0] ceil);
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        cfg_ceiling = ceil;
        cfg_hi_thr = 1'b0;
        cfg_atten_sel = 2'd0;
        cfg_rec_big = 1'b0;
        cfg_zc_bypass = 1'b1;
        cfg_wait = 12'd4;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input int l, input int r);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_left  = SMP_W'(l);
        smp_right = SMP_W'(r);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(7'h2A);
        repeat (2) @(negedge clk);
        check("R1 target", gain_target, 'h2A);
        check("R1 left", gain_left, 'h2A);
        check("R1 right", gain_right, 'h2A);
    endtask

    task automatic t_atten();
        do_reset(7'h47);
        cfg_atten_sel = 2'd3; send(20000, 0); check("R3 4 steps", gain_target, 'h43);
        cfg_atten_sel = 2'd0; send(20000, 0); check("R3 1 step", gain_target, 'h42);
        cfg_atten_sel = 2'd1; send(20000, 0); check("R3 2 steps", gain_target, 'h40);
        cfg_atten_sel = 2'd2; send(20000, 0); check("R3 3 steps", gain_target, 'h3D);
        repeat (3) @(negedge clk);
        check("R3 hold without strobe", gain_target, 'h3D);
    endtask

    task automatic t_thresh();
        do_reset(7'h40);
        cfg_hi_thr = 1'b1; send(18000, 0);   check("R2 high level ignores 18000", gain_target, 'h40);
        cfg_hi_thr = 1'b0; send(18000, 0);   check("R2 low level trips 18000", gain_target, 'h3F);
        send(0, -20000);                     check("R2 right negative trips", gain_target, 'h3E);
        cfg_hi_thr = 1'b1; send(20675, 100); check("R2 boundary 20675 no trip", gain_target, 'h3E);
        send(20676, 100);                    check("R2 boundary 20676 trips", gain_target, 'h3D);
        cfg_hi_thr = 1'b0; send(16423, 0);   check("R2 boundary 16423 no trip", gain_target, 'h3D);
    endtask

    task automatic t_sat();
        do_reset(7'h02);
        cfg_atten_sel = 2'd3;
        send(30000, 0);  check("R4 floor", gain_target, 'h00);
        send(-32768, 0); check("R4 stays at floor", gain_target, 'h00);
    endtask

    task automatic t_recover();
        do_reset(7'h40);
        cfg_atten_sel = 2'd3; cfg_rec_big = 1'b1;
        for (int i = 0; i < 4; i++) send(30000, 30000);
        check("R3 four events", gain_target, 'h30);
        for (int i = 0; i < 3; i++) send(100, -100);
        check("R5 no recovery before wait", gain_target, 'h30);
        send(100, -100); check("R6 step of 2", gain_target, 'h32);
        cfg_rec_big = 1'b0;
        for (int i = 0; i < 4; i++) send(100, 100);
        check("R6 step of 1", gain_target, 'h33);
        cfg_ceiling = 7'h34; cfg_rec_big = 1'b1;
        for (int i = 0; i < 4; i++) send(100, 100);
        check("R6 clipped at ceiling", gain_target, 'h34);
        for (int i = 0; i < 4; i++) send(100, 100);
        check("R6 stays at ceiling", gain_target, 'h34);
    endtask

    task automatic t_band();
        do_reset(7'h40);
        send(20000, 0); check("R5 setup", gain_target, 'h3F);
        for (int i = 0; i < 3; i++) send(13045, 0);
        send(0, -16423);
        for (int i = 0; i < 3; i++) send(100, 0);
        check("R5 band sample restarts wait", gain_target, 'h3F);
        send(100, 0); check("R5 recovery after full wait", gain_target, 'h40);
    endtask

    task automatic t_zc();
        do_reset(7'h40);
        cfg_zc_bypass = 1'b0;
        send(20000, 20000);
        check("R7 target moved", gain_target, 'h3F);
        check("R10 left waits", gain_left, 'h40);
        check("R10 right waits", gain_right, 'h40);
        repeat (3) @(negedge clk);
        check("R10 left idle hold", gain_left, 'h40);
        send(-15000, 15000);
        check("R7 left commits at crossing", gain_left, 'h3F);
        check("R8 right still pending", gain_right, 'h40);
        send(-15000, 15000); send(-15000, 15000);
        check("R8 right pending before timeout", gain_right, 'h40);
        send(-15000, 15000);
        check("R8 right commits at timeout", gain_right, 'h3F);
        check("R8 target unchanged", gain_target, 'h3F);
    endtask

    task automatic t_bypass();
        do_reset(7'h40);
        cfg_atten_sel = 2'd1;
        send(20000, 20000);
        check("R9 target", gain_target, 'h3E);
        check("R9 left immediate", gain_left, 'h3E);
        check("R9 right immediate", gain_right, 'h3E);
    endtask

    initial begin
        t_reset();
        t_atten();
        t_thresh();
        t_sat();
        t_recover();
        t_band();
        t_zc();
        t_bypass();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule